// File: doc/BRIEF.md
# Spread-Spectrum Divider Word Modulator

This block generates the fractional feedback-divider word for one clock synthesizer channel. It starts from a programmable base multiplier N and a resolution group, then moves the word along a triangular profile so that the synthesized frequency is spread. The word counts in units of the finest frequency step. A 3-bit magnitude code chooses between a one-sided profile that only lowers the frequency and a symmetric profile that swings above and below the nominal value. Each code also sets the depth of the swing.

The triangle is stepped by an internal prescaler whose terminal count is an input, so the modulation rate can be placed near 30 to 33 kHz from any reference clock. A new depth or a new profile is taken only at the zero point of the triangle. Turning spread off therefore brings the word back to exactly the nominal value without a jump. The symmetric profile is accepted only while on-the-fly N programming is enabled. A one-cycle strobe marks each new step of the profile.

Top module: `spread_word_mod`

## Requirements
- R1: While reset is held, and right after it is released, `divWord` equals N_RESET × 2^FRAC_W (38400 with the defaults, resolution group 0) and `wordValid` is low.
- R2: While spread is inactive, `divWord` equals Ns × 2^FRAC_W exactly. Ns is the base shifted left by 0, 1 or 2 for resolution groups 0, 1 and 2/3, whose steps are 0.666667, 1.333333 and 2.666667 MHz.
- R3: While `nProgEn` is 1, `baseN` and `resSel` are captured every clock and `divWord` reflects them two clocks later, with no reset. While `nProgEn` is 0, changes on these inputs have no effect on `divWord`.
- R4: Codes 0 to 3 give a downward triangle of depth k/800 with k = 2, 4, 6, 8 (0.25 % to 1 %). The word is Ns×256 − floor(P×r/2^STEP_BITS), where P = floor(Ns×k×1311/4096) and r is the ramp position.
- R5: Codes 4 to 7 give a symmetric triangle of ±k/800 with k = 1, 2, 3, 4. The word is Ns×256 ± floor(P×r/2^STEP_BITS). The half that starts when center mode is entered lies above nominal, and the following halves alternate sides.
- R6: The ramp moves one step every rateDiv+1 clocks and never goes beyond 2^STEP_BITS. In down mode the step size is 1, and in center mode it is 2. One triangle period takes 2^(STEP_BITS+1) steps in both modes.
- R7: `wordValid` is a single-cycle pulse once per ramp step. Pulses are rateDiv+1 clocks apart, and each pulse appears in the first cycle in which `divWord` carries the new ramp position.
- R8: Spread becomes active only when both `globalSpreadEn` and `chanSpreadEn` are 1.
- R9: A center code presented while `nProgEn` is 0 is treated as spread off.
- R10: The mode and the depth code are latched only when the ramp is at zero. After spread is disabled, the word reaches Ns×256 at the end of the current half-triangle and does not jump before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baseN | input | N_W | Base multiplier N |
| resSel | input | 2 | Resolution group (0: ×1, 1: ×2, 2/3: ×4 of the finest step) |
| magCode | input | 3 | Spread profile and magnitude code |
| globalSpreadEn | input | 1 | Global spread enable |
| chanSpreadEn | input | 1 | Channel spread enable |
| nProgEn | input | 1 | On-the-fly N programming enable |
| rateDiv | input | RATE_W | Prescaler terminal count per ramp step |
| divWord | output | N_W+FRAC_W+3 | Instantaneous divider word, FRAC_W fractional bits |
| wordValid | output | 1 | One-cycle strobe per ramp step |

## Verification
The bench builds the block with STEP_BITS = 4, which gives 16 steps per half-triangle and 32 steps per period. It drives rateDiv at 3 and then at 5. With these settings each 40-step batch crosses at least one full triangle and one zero point, so depth changes, side alternation in center mode, and the return to nominal can all be seen within a few thousand cycles. The default widths are kept, so Ns reaches 800 with resolution group 2 and the word uses its fractional bits.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic [1:0] {
    SPR_OFF    = 2'd0,
    SPR_DOWN   = 2'd1,
    SPR_CENTER = 2'd2
  } sprMode_e;

  // strobes and latched configuration handed from control to datapath
  typedef struct packed {
    logic     step;     // ramp advanced in the previous cycle
    sprMode_e mode;     // active profile
    logic     negSide;  // center profile currently below nominal
    logic [3:0] kUnits; // depth in 1/800 units
  } ssmCtl_t;

endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int STEP_BITS = 6,
  parameter int RATE_W    = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RATE_W-1:0]   rateDiv,
  input  logic                globalSpreadEn,
  input  logic                chanSpreadEn,
  input  logic [2:0]          magCode,
  input  logic                nProgEn,
  output ssmCtl_t             ctl,
  output logic [STEP_BITS:0]  ramp
);

  localparam int RAMP_W = STEP_BITS + 1;
  localparam logic [RAMP_W-1:0] RAMP_TOP = {1'b1, {STEP_BITS{1'b0}}};

  logic [RATE_W-1:0] preCnt;
  logic              tick;
  logic              upDir, upNext;
  logic              negSide, negNext;
  sprMode_e          modeReg, modeNext, reqMode;
  logic [3:0]        kReg, kNext, reqK;
  logic [RAMP_W-1:0] rampNext, incStep, startStep;
  logic              stepReg;

  assign tick = (preCnt >= rateDiv);

  // requested profile from the enables and the code
  always_comb begin
    if (!(globalSpreadEn && chanSpreadEn)) begin
      reqMode = SPR_OFF;
    end else if (magCode[2]) begin
      reqMode = nProgEn ? SPR_CENTER : SPR_OFF;
    end else begin
      reqMode = SPR_DOWN;
    end
    if (magCode[2]) begin
      reqK = {1'b0, magCode} - 4'd3;
    end else begin
      reqK = {1'b0, magCode[1:0], 1'b0} + 4'd2;
    end
  end

  assign incStep   = (modeReg == SPR_CENTER) ? RAMP_W'(2) : RAMP_W'(1);
  assign startStep = (reqMode == SPR_CENTER) ? RAMP_W'(2) : RAMP_W'(1);

  always_comb begin
    rampNext = ramp;
    upNext   = upDir;
    negNext  = negSide;
    modeNext = modeReg;
    kNext    = kReg;
    if (tick) begin
      if (ramp == '0) begin
        modeNext = reqMode;
        kNext    = reqK;
        if (reqMode == SPR_CENTER) begin
          negNext = (modeReg == SPR_CENTER) ? ~negSide : 1'b0;
        end else begin
          negNext = 1'b0;
        end
        if (reqMode == SPR_OFF) begin
          rampNext = '0;
          upNext   = 1'b1;
        end else begin
          rampNext = startStep;
          upNext   = (startStep != RAMP_TOP);
        end
      end else if (upDir) begin
        rampNext = ramp + incStep;
        upNext   = (rampNext != RAMP_TOP);
      end else begin
        rampNext = ramp - incStep;
        upNext   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      ramp    <= '0;
      upDir   <= 1'b1;
      negSide <= 1'b0;
      modeReg <= SPR_OFF;
      kReg    <= '0;
      stepReg <= 1'b0;
    end else begin
      preCnt  <= tick ? '0 : preCnt + RATE_W'(1);
      ramp    <= rampNext;
      upDir   <= upNext;
      negSide <= negNext;
      modeReg <= modeNext;
      kReg    <= kNext;
      stepReg <= tick;
    end
  end

  assign ctl.step    = stepReg;
  assign ctl.mode    = modeReg;
  assign ctl.negSide = negSide;
  assign ctl.kUnits  = kReg;

  AST_RAMP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ramp <= RAMP_TOP); // R6

  AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(ramp)); // R6

  AST_SWITCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg != $past(modeReg)) |-> ($past(ramp) == '0)); // R10

  AST_CENTER_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == SPR_CENTER && $past(modeReg) != SPR_CENTER) |-> $past(nProgEn)); // R9

  AST_BOTH_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg != SPR_OFF && $past(modeReg) == SPR_OFF)
      |-> $past(globalSpreadEn && chanSpreadEn)); // R8

endmodule

// File: rtl/ssm_datapath.sv
module ssm_datapath
  import ssm_pkg::*;
#(
  parameter int N_W       = 8,
  parameter int FRAC_W    = 8,
  parameter int STEP_BITS = 6,
  parameter int WORD_W    = N_W + FRAC_W + 3,
  parameter int N_RESET   = 150,
  parameter int RES_RESET = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_W-1:0]     baseN,
  input  logic [1:0]         resSel,
  input  logic               nProgEn,
  input  ssmCtl_t            ctl,
  input  logic [STEP_BITS:0] ramp,
  output logic [WORD_W-1:0]  divWord,
  output logic               wordValid
);

  localparam int NS_W     = N_W + 2;
  localparam int SCALE_SH = 20;
  localparam int RECIP    = (2**SCALE_SH + 400) / 800;
  localparam int RECIP_W  = $clog2(RECIP + 1);
  localparam int PROD_W   = NS_W + 4 + RECIP_W;
  localparam int RAMP_W   = STEP_BITS + 1;
  localparam int OFFP_W   = PROD_W + RAMP_W;
  localparam int RESET_SHIFT = (RES_RESET == 0) ? 0 : ((RES_RESET == 1) ? 1 : 2);
  localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'(N_RESET) << (RESET_SHIFT + FRAC_W);

  logic [N_W-1:0]    baseReg;
  logic [1:0]        resReg;
  logic [NS_W-1:0]   nsVal;
  logic [WORD_W-1:0] wordBase, offVal, wordNext;
  logic [PROD_W-1:0] peakProd, peakVal;
  logic [OFFP_W-1:0] offProd;
  logic              raise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= N_W'(N_RESET);
      resReg  <= 2'(RES_RESET);
    end else if (nProgEn) begin
      baseReg <= baseN;
      resReg  <= resSel;
    end
  end

  // base scaled to units of the finest step
  always_comb begin
    case (resReg)
      2'd0:    nsVal = NS_W'(baseReg);
      2'd1:    nsVal = NS_W'(baseReg) << 1;
      default: nsVal = NS_W'(baseReg) << 2;
    endcase
  end

  assign wordBase = WORD_W'(nsVal) << FRAC_W;
  assign peakProd = PROD_W'(nsVal) * PROD_W'(ctl.kUnits) * PROD_W'(RECIP);
  assign peakVal  = peakProd >> (SCALE_SH - FRAC_W);
  assign offProd  = OFFP_W'(peakVal) * OFFP_W'(ramp);
  assign offVal   = WORD_W'(offProd >> STEP_BITS);
  assign raise    = (ctl.mode == SPR_CENTER) && !ctl.negSide;
  assign wordNext = raise ? (wordBase + offVal) : (wordBase - offVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divWord   <= RESET_WORD;
      wordValid <= 1'b0;
    end else begin
      divWord   <= wordNext;
      wordValid <= ctl.step;
    end
  end

  AST_OFF_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == SPR_OFF) |=> (divWord == $past(wordBase))); // R2

  AST_DOWN_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == SPR_DOWN) |=> (divWord <= $past(wordBase))); // R4

  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !$past(nProgEn) |-> $stable(baseReg)); // R3

endmodule

// File: rtl/spread_word_mod.sv
module spread_word_mod
  import ssm_pkg::*;
#(
  parameter int N_W       = 8,
  parameter int FRAC_W    = 8,
  parameter int STEP_BITS = 6,
  parameter int RATE_W    = 12,
  parameter int N_RESET   = 150,
  parameter int RES_RESET = 0,
  localparam int WORD_W   = N_W + FRAC_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_W-1:0]    baseN,
  input  logic [1:0]        resSel,
  input  logic [2:0]        magCode,
  input  logic              globalSpreadEn,
  input  logic              chanSpreadEn,
  input  logic              nProgEn,
  input  logic [RATE_W-1:0] rateDiv,
  output logic [WORD_W-1:0] divWord,
  output logic              wordValid
);

  ssmCtl_t            ctl;
  logic [STEP_BITS:0] ramp;

  ssm_ctrl #(
    .STEP_BITS (STEP_BITS),
    .RATE_W    (RATE_W)
  ) i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .rateDiv        (rateDiv),
    .globalSpreadEn (globalSpreadEn),
    .chanSpreadEn   (chanSpreadEn),
    .magCode        (magCode),
    .nProgEn        (nProgEn),
    .ctl            (ctl),
    .ramp           (ramp)
  );

  ssm_datapath #(
    .N_W       (N_W),
    .FRAC_W    (FRAC_W),
    .STEP_BITS (STEP_BITS),
    .WORD_W    (WORD_W),
    .N_RESET   (N_RESET),
    .RES_RESET (RES_RESET)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .baseN     (baseN),
    .resSel    (resSel),
    .nProgEn   (nProgEn),
    .ctl       (ctl),
    .ramp      (ramp),
    .divWord   (divWord),
    .wordValid (wordValid)
  );

endmodule

// File: tb/test_spread_word_mod.sv
module test_spread_word_mod;

  localparam int CLK_PERIOD = 10;
  localparam int N_W       = 8;
  localparam int FRAC_W    = 8;
  localparam int STEP_BITS = 4;
  localparam int RATE_W    = 12;
  localparam int WORD_W    = N_W + FRAC_W + 3;
  localparam int RAMP_TOP  = 1 << STEP_BITS;

  logic              clk;
  logic              rstN;
  logic [N_W-1:0]    baseN;
  logic [1:0]        resSel;
  logic [2:0]        magCode;
  logic              globalSpreadEn;
  logic              chanSpreadEn;
  logic              nProgEn;
  logic [RATE_W-1:0] rateDiv;
  logic [WORD_W-1:0] divWord;
  logic              wordValid;

  spread_word_mod #(
    .N_W       (N_W),
    .FRAC_W    (FRAC_W),
    .STEP_BITS (STEP_BITS),
    .RATE_W    (RATE_W)
  ) i_spread_word_mod (
    .clk            (clk),
    .rstN           (rstN),
    .baseN          (baseN),
    .resSel         (resSel),
    .magCode        (magCode),
    .globalSpreadEn (globalSpreadEn),
    .chanSpreadEn   (chanSpreadEn),
    .nProgEn        (nProgEn),
    .rateDiv        (rateDiv),
    .divWord        (divWord),
    .wordValid      (wordValid)
  );

  typedef struct {
    longint word;
    string  tag;
  } expItem_t;

  expItem_t expQ[$];
  int       checks = 0;
  int       errors = 0;
  longint   cycleNo = 0;
  longint   lastValid = -1;

  // reference model state, derived from the requirements
  int mR = 0, mUp = 1, mNeg = 0, mMode = 0, mK = 0, mBase = 150, mRes = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycleNo <= cycleNo + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint nsOf(input int b, input int r);
    if (r == 0) return longint'(b);
    if (r == 1) return longint'(b) * 2;
    return longint'(b) * 4;
  endfunction

  // advance the model by one ramp step and return the expected word (R4, R5, R6, R8, R9, R10)
  task automatic modelStep(output longint w);
    int reqMode, reqK, inc;
    longint ns, peak, off;
    if (!(globalSpreadEn && chanSpreadEn)) reqMode = 0;
    else if (magCode[2]) reqMode = nProgEn ? 2 : 0;
    else reqMode = 1;
    reqK = magCode[2] ? int'(magCode) - 3 : 2 * (int'(magCode) + 1);
    if (mR == 0) begin
      if (reqMode == 2) mNeg = (mMode == 2) ? 1 - mNeg : 0;
      else mNeg = 0;
      mMode = reqMode;
      mK = reqK;
      if (mMode == 0) begin
        mR = 0;
        mUp = 1;
      end else begin
        mR = (mMode == 2) ? 2 : 1;
        mUp = (mR != RAMP_TOP) ? 1 : 0;
      end
    end else begin
      inc = (mMode == 2) ? 2 : 1;
      if (mUp != 0) begin
        mR += inc;
        mUp = (mR != RAMP_TOP) ? 1 : 0;
      end else begin
        mR -= inc;
        mUp = 0;
      end
    end
    ns   = nsOf(mBase, mRes);
    peak = (ns * mK * 1311) >> 12;
    off  = (peak * mR) >> STEP_BITS;
    w = (mMode == 2 && mNeg == 0) ? ns * 256 + off : ns * 256 - off;
  endtask

  // driver: pushes the expected words of the next n steps and waits until they are consumed
  task automatic pushSteps(input int n, input string tag);
    longint w;
    if (nProgEn) begin
      mBase = int'(baseN);
      mRes  = int'(resSel);
    end
    for (int i = 0; i < n; i++) begin
      modelStep(w);
      expQ.push_back('{w, tag});
    end
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // monitor: compares each strobed word against the scoreboard
  always @(negedge clk) begin : monBlk
    expItem_t it;
    if (rstN && wordValid) begin
      if (lastValid >= 0)
        check((cycleNo - lastValid) == longint'(rateDiv) + 1, "R7 strobe spacing",
              cycleNo - lastValid, longint'(rateDiv) + 1);
      lastValid = cycleNo;
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected strobe", 1, 0);
      end else begin
        it = expQ.pop_front();
        check(longint'(divWord) == it.word, it.tag, longint'(divWord), it.word);
      end
    end
  end

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : mainSeq
    rstN = 1'b0;
    baseN = 8'd99;
    resSel = 2'd0;
    magCode = 3'd0;
    globalSpreadEn = 1'b0;
    chanSpreadEn = 1'b0;
    nProgEn = 1'b0;
    rateDiv = 12'd3;
    repeat (3) @(negedge clk);
    check(longint'(divWord) == 38400, "R1 reset word", longint'(divWord), 38400);
    check(wordValid == 1'b0, "R1 reset strobe", longint'(wordValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(longint'(divWord) == 38400, "R1 word after release", longint'(divWord), 38400);

    pushSteps(3, "R2 off default");

    baseN = 8'd200;
    resSel = 2'd1;
    pushSteps(3, "R3 write ignored without nProgEn");

    nProgEn = 1'b1;
    repeat (2) @(negedge clk);
    check(longint'(divWord) == 102400, "R3 immediate N", longint'(divWord), 102400);
    pushSteps(3, "R2 off res x2");

    globalSpreadEn = 1'b1;
    chanSpreadEn = 1'b1;
    magCode = 3'd1;
    pushSteps(40, "R4 down 0.5%");

    magCode = 3'd3;
    pushSteps(40, "R10 code change at zero");

    magCode = 3'd6;
    nProgEn = 1'b0;
    pushSteps(40, "R9 center refused");

    nProgEn = 1'b1;
    pushSteps(40, "R5 center 0.375%");

    resSel = 2'd2;
    magCode = 3'd7;
    pushSteps(40, "R5 center res x4");

    resSel = 2'd3;
    magCode = 3'd0;
    pushSteps(40, "R4 down 0.25% res group 3");

    rateDiv = 12'd5;
    pushSteps(20, "R6 slower step rate");

    chanSpreadEn = 1'b0;
    pushSteps(40, "R8 channel off returns to nominal");

    chanSpreadEn = 1'b1;
    globalSpreadEn = 1'b0;
    pushSteps(20, "R8 global off");

    globalSpreadEn = 1'b1;
    magCode = 3'd5;
    resSel = 2'd0;
    pushSteps(20, "R5 center 0.25%");
    baseN = 8'd180;
    pushSteps(40, "R3 on-the-fly N during spread");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule